// File: doc/BRIEF.md
# OLED Power-Up Command Sequencer over I2C

This block brings a small monochrome OLED display controller out of reset by writing its power-up command list over a two-wire I2C bus. It is a bit-level bus controller. It drives the clock line directly. It drives the data line in open-drain fashion: an enable pulls the line low, and the resolved line level is read back on a separate input. The command list is held in a small internal ROM, so software or a boot controller only has to pulse `start` once and then wait for `done` or `err`.

A single pulse on `start` produces one write transaction. The transaction opens with a start condition. It then carries the device address byte (7-bit address plus a write bit of 0), a control byte of 0x00 that marks everything after it as commands, and the 25 command bytes, and it closes with a stop condition. Each of these bytes is followed by an acknowledge clock in which the device must hold the data line low. If any acknowledge is missing, the block ends the transaction with a stop and raises a sticky error.

Bus timing comes from a system-clock counter with separate parameters for the SCL low time and the SCL high time. The defaults give at least 4.7 us low and 4.0 us high for standard-mode operation at a 50 MHz system clock. Because no device reads data back, the block supports neither clock stretching nor multi-controller arbitration.

Top module: `oled_init_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `scl` is 1, `sda_oe` is 0, and `busy`, `done` and `err` are 0.
- R2: A `start` pulse in idle produces exactly one start condition and one stop condition. Between them the device receives, in order: the address byte, the control byte 0x00, and the 25 commands AE, D5, 80, A8, 3F, D3, 00, 40, 8D, 14, 20, 00, A1, C8, DA, 12, 81, CF, D9, F1, DB, 40, A4, A6, AF (27 bytes in total).
- R3: The address byte is {address, 0}. The address is 0x3C when `addr_sel` is 0, which gives the byte 0x78, and 0x3D when `addr_sel` is 1, which gives the byte 0x7A.
- R4: Every SCL low period inside a transaction lasts exactly `LOW_CYCLES` clocks. Every SCL high period that starts with a rising SCL edge and ends with a falling SCL edge lasts exactly `HIGH_CYCLES` clocks.
- R5: SDA changes only while SCL is low, apart from the start condition (SDA falls while SCL is high) and the stop condition (SDA rises while SCL is high).
- R6: Each byte is shifted out MSB first. During every acknowledge clock `sda_oe` is 0, so the device alone decides the line level.
- R7: If the line is high when the acknowledge of any byte is sampled, the block ends with a stop right after that byte and sends no further byte. It then sets `err` and leaves `done` at 0.
- R8: When every byte is acknowledged, `done` is set at the end of the stop condition and `err` stays 0. Both flags hold their values until the next accepted `start`.
- R9: A `start` accepted in idle clears `done` and `err` in the next cycle and raises `busy`. A `start` pulse while `busy` is 1 has no effect on the bus.
- R10: Once a transaction has ended, `busy` is 0, `scl` is 1 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to send the power-up list |
| addr_sel | input | 1 | Static address choice: 0 gives 0x3C, 1 gives 0x3D |
| sda_in | input | 1 | Resolved level of the SDA line |
| scl | output | 1 | I2C clock line |
| sda_oe | output | 1 | Pull SDA low when 1; release SDA when 0 |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | Sticky: the last transaction was fully acknowledged |
| err | output | 1 | Sticky: the last transaction ended on a missing acknowledge |

## Verification
A wrong byte or bit counter appears at the ports within one byte time. It shows up as a wrong or misordered byte at the bench's bus receiver, as a byte count other than 27, or as `sda_oe` still asserted during an acknowledge clock. A bad phase counter changes the very next SCL low or high period, and the bench measures every one of those periods. If the state machine moves SDA at the wrong moment, the receiver sees an extra start or stop condition in the same transaction. A mishandled acknowledge changes the byte count and the `done`/`err` pair when `busy` falls.

// File: rtl/oinit_pkg.sv
// Shared definitions for the OLED power-up sequencer.
// Assumes: the command ROM and the top module agree on the list length.
package oinit_pkg;

    // Number of bytes in the stored power-up command list.
    localparam int CMD_COUNT = 25;
    // Width of an index into the command list.
    localparam int ROM_IDX_W = $clog2(CMD_COUNT);

    // Bus sequencing phases.
    typedef enum logic [2:0] {
        ST_IDLE,     // bus released, SCL high
        ST_START,    // SDA held low while SCL high (start condition)
        ST_BIT_LO,   // SCL low, SDA updated mid-phase
        ST_BIT_HI,   // SCL high, SDA sampled at end of phase
        ST_STOP_LO,  // SCL low, SDA pulled low ahead of stop
        ST_STOP_HI,  // SCL high, SDA still low
        ST_STOP_REL  // SDA released while SCL high (stop condition)
    } seq_state_t;

endpackage

// File: rtl/oinit_cmd_rom.sv
// Read-only table of the display power-up commands, in send order.
// Assumes: idx below oinit_pkg::CMD_COUNT; other indices return a no-op byte.
module oinit_cmd_rom
    import oinit_pkg::*;
(
    input  logic [ROM_IDX_W-1:0] idx,
    output logic [7:0]           data
);

    // Purpose: combinational lookup of one command byte.
    always_comb begin
        case (idx)
            5'd0:    data = 8'hAE;
            5'd1:    data = 8'hD5;
            5'd2:    data = 8'h80;
            5'd3:    data = 8'hA8;
            5'd4:    data = 8'h3F;
            5'd5:    data = 8'hD3;
            5'd6:    data = 8'h00;
            5'd7:    data = 8'h40;
            5'd8:    data = 8'h8D;
            5'd9:    data = 8'h14;
            5'd10:   data = 8'h20;
            5'd11:   data = 8'h00;
            5'd12:   data = 8'hA1;
            5'd13:   data = 8'hC8;
            5'd14:   data = 8'hDA;
            5'd15:   data = 8'h12;
            5'd16:   data = 8'h81;
            5'd17:   data = 8'hCF;
            5'd18:   data = 8'hD9;
            5'd19:   data = 8'hF1;
            5'd20:   data = 8'hDB;
            5'd21:   data = 8'h40;
            5'd22:   data = 8'hA4;
            5'd23:   data = 8'hA6;
            5'd24:   data = 8'hAF;
            default: data = 8'hE3;
        endcase
    end

endmodule

// File: rtl/oinit_phase_timer.sv
// Counts system clocks within one SCL phase.
// It flags the middle and the last cycle of the phase.
// Assumes: the caller changes high_sel only in the cycle after `last`,
// when the count has already wrapped to zero.
module oinit_phase_timer #(
    parameter int LOW_CYCLES  = 235,
    parameter int HIGH_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic high_sel,
    output logic mid,
    output logic last
);

    localparam int MAX_CYC = (LOW_CYCLES > HIGH_CYCLES) ? LOW_CYCLES : HIGH_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Purpose: pick the length of the current phase.
    always_comb limit = high_sel ? CNT_W'(HIGH_CYCLES) : CNT_W'(LOW_CYCLES);

    assign last = run && (cnt == limit - CNT_W'(1));
    assign mid  = run && (cnt == (limit >> 1));

    // Purpose: advance the count and wrap it at the end of every phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) cnt <= '0;
        else                        cnt <= cnt + CNT_W'(1);
    end

    AST_PHASE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(MAX_CYC)); // R4
    AST_PHASE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> cnt == '0); // R4

endmodule

// File: rtl/oled_init_seq.sv
// I2C write controller that sends the OLED power-up list in one transaction.
// The transaction is: start, address+W, 0x00 control byte, commands, stop.
// An ACK is sampled after every byte.
// Assumes: a single bus controller, no clock stretching, and an SDA line
// pulled up externally so that it reads 1 when nobody drives it.
module oled_init_seq
    import oinit_pkg::*;
#(
    parameter int LOW_CYCLES  = 235,
    parameter int HIGH_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic addr_sel,
    input  logic sda_in,
    output logic scl,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic err
);

    localparam int       NUM_BYTES = CMD_COUNT + 2;
    localparam int       BIDX_W    = $clog2(NUM_BYTES);
    localparam logic [6:0] DEV_ADDR_BASE = 7'h3C;
    localparam logic [3:0] ACK_BIT = 4'd8;

    seq_state_t           state;
    logic [BIDX_W-1:0]    byte_idx;
    logic [3:0]           bit_idx;
    logic                 sda_oe_q;
    logic                 nack_q;
    logic                 done_q;
    logic                 err_q;
    logic                 ph_mid;
    logic                 ph_last;
    logic                 ph_high;
    logic [ROM_IDX_W-1:0] rom_idx;
    logic [7:0]           rom_byte;
    logic [7:0]           cur_byte;
    logic [2:0]           bit_pos;

    // Purpose: phase lengths for SCL low and high.
    oinit_phase_timer #(
        .LOW_CYCLES (LOW_CYCLES),
        .HIGH_CYCLES(HIGH_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .high_sel(ph_high),
        .mid     (ph_mid),
        .last    (ph_last)
    );

    oinit_cmd_rom u_rom (
        .idx (rom_idx),
        .data(rom_byte)
    );

    // Purpose: select the byte now on the wire: address, control, or command.
    always_comb begin
        rom_idx = ROM_IDX_W'(byte_idx - BIDX_W'(2));
        bit_pos = 3'(4'd7 - bit_idx);
        if (byte_idx == '0)                cur_byte = {DEV_ADDR_BASE | {6'd0, addr_sel}, 1'b0};
        else if (byte_idx == BIDX_W'(1))   cur_byte = 8'h00;
        else                               cur_byte = rom_byte;
    end

    // Purpose: decode bus levels and phase type from the state.
    always_comb begin
        busy    = (state != ST_IDLE);
        scl     = !(state == ST_BIT_LO || state == ST_STOP_LO);
        ph_high = (state == ST_START || state == ST_BIT_HI ||
                   state == ST_STOP_HI || state == ST_STOP_REL);
    end

    assign sda_oe = sda_oe_q;
    assign done   = done_q;
    assign err    = err_q;

    // Purpose: transaction state machine, bit and byte counters, status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_idx <= '0;
            bit_idx  <= '0;
            sda_oe_q <= 1'b0;
            nack_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_START;
                    sda_oe_q <= 1'b1;
                    byte_idx <= '0;
                    bit_idx  <= '0;
                    nack_q   <= 1'b0;
                    done_q   <= 1'b0;
                    err_q    <= 1'b0;
                end
                ST_START: if (ph_last) state <= ST_BIT_LO;
                ST_BIT_LO: begin
                    if (ph_mid)  sda_oe_q <= (bit_idx == ACK_BIT) ? 1'b0 : !cur_byte[bit_pos];
                    if (ph_last) state <= ST_BIT_HI;
                end
                ST_BIT_HI: if (ph_last) begin
                    if (bit_idx != ACK_BIT) begin
                        bit_idx <= bit_idx + 4'd1;
                        state   <= ST_BIT_LO;
                    end else if (sda_in) begin
                        nack_q <= 1'b1;
                        state  <= ST_STOP_LO;
                    end else if (byte_idx == BIDX_W'(NUM_BYTES - 1)) begin
                        state <= ST_STOP_LO;
                    end else begin
                        byte_idx <= byte_idx + BIDX_W'(1);
                        bit_idx  <= '0;
                        state    <= ST_BIT_LO;
                    end
                end
                ST_STOP_LO: begin
                    if (ph_mid)  sda_oe_q <= 1'b1;
                    if (ph_last) state <= ST_STOP_HI;
                end
                ST_STOP_HI: if (ph_last) begin
                    sda_oe_q <= 1'b0;
                    state    <= ST_STOP_REL;
                end
                ST_STOP_REL: if (ph_last) begin
                    state  <= ST_IDLE;
                    done_q <= !nack_q;
                    err_q  <= nack_q;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && $past(state) == ST_BIT_HI) |-> $stable(sda_oe_q)); // R5
    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && bit_idx == ACK_BIT) |-> !sda_oe); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8
    AST_IDLE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !sda_oe)); // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !$past(busy)) |-> (busy && !done && !err)); // R9
    AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && ph_last && bit_idx == ACK_BIT && sda_in) |=> state == ST_STOP_LO); // R7

endmodule

// File: tb/test_oled_init_seq.sv
// Directed bench with an I2C device model on the bus.
// The model logs the received bytes, bus conditions and SCL phase lengths.
module test_oled_init_seq;

    localparam int LOW_C  = 8;
    localparam int HIGH_C = 6;
    localparam logic [7:0] EXP_CMDS [0:24] = '{
        8'hAE, 8'hD5, 8'h80, 8'hA8, 8'h3F, 8'hD3, 8'h00, 8'h40, 8'h8D,
        8'h14, 8'h20, 8'h00, 8'hA1, 8'hC8, 8'hDA, 8'h12, 8'h81, 8'hCF,
        8'hD9, 8'hF1, 8'hDB, 8'h40, 8'hA4, 8'hA6, 8'hAF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic addr_sel = 1'b0;
    logic scl, sda_oe, busy, done, err;
    logic dev_pull = 1'b0;
    logic sda_line;

    int n_checks = 0;
    int n_bad = 0;
    int cycles = 0;

    // device model state
    logic [6:0] dev_addr = 7'h3C;
    int         nack_at = -1;
    logic       prev_scl = 1'b1, prev_sda = 1'b1, in_frame = 1'b0, seen_rise = 1'b0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] log_b [0:31];
    int bitcnt = 0, nbytes = 0, starts = 0, stops = 0, ack_drive = 0;
    int lo_run = 0, hi_run = 0, lo_min = 1000, lo_max = 0, hi_min = 1000, hi_max = 0;

    assign sda_line = !(sda_oe || dev_pull);

    oled_init_seq #(.LOW_CYCLES(LOW_C), .HIGH_CYCLES(HIGH_C)) i_oled_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_sel(addr_sel),
        .sda_in(sda_line), .scl(scl), .sda_oe(sda_oe), .busy(busy),
        .done(done), .err(err)
    );

    always #4 clk = !clk;

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    // I2C device model
    always @(posedge clk) begin
        prev_scl <= scl;
        prev_sda <= sda_line;
        if (scl && prev_scl && prev_sda && !sda_line) begin
            starts <= starts + 1; in_frame <= 1'b1; bitcnt <= 0; seen_rise <= 1'b0;
        end else if (scl && prev_scl && !prev_sda && sda_line) begin
            stops <= stops + 1; in_frame <= 1'b0;
        end
        if (scl && !prev_scl) begin
            hi_run <= 1; seen_rise <= 1'b1;
            if (in_frame) begin
                if (lo_run < lo_min) lo_min <= lo_run;
                if (lo_run > lo_max) lo_max <= lo_run;
                if (bitcnt < 8) begin
                    shreg <= {shreg[6:0], sda_line}; bitcnt <= bitcnt + 1;
                end else if (bitcnt == 8) begin
                    bitcnt <= 9;
                    if (sda_oe) ack_drive <= ack_drive + 1;
                end
            end
        end else if (scl) hi_run <= hi_run + 1;
        if (!scl && prev_scl) begin
            lo_run <= 1;
            if (in_frame && seen_rise) begin
                if (hi_run < hi_min) hi_min <= hi_run;
                if (hi_run > hi_max) hi_max <= hi_run;
            end
            if (in_frame && bitcnt == 8) begin
                if (nbytes < 32) log_b[nbytes] <= shreg;
                dev_pull <= (nbytes != nack_at) && (nbytes != 0 || (shreg[7:1] == dev_addr && !shreg[0]));
            end else if (in_frame && bitcnt == 9) begin
                dev_pull <= 1'b0; bitcnt <= 0; nbytes <= nbytes + 1;
            end
        end else if (!scl) lo_run <= lo_run + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_model(input logic [6:0] a, input int nk);
        @(negedge clk);
        dev_addr = a; nack_at = nk;
        nbytes = 0; starts = 0; stops = 0; ack_drive = 0;
        lo_min = 1000; lo_max = 0; hi_min = 1000; hi_max = 0;
    endtask

    task automatic pulse_start(input logic sel);
        @(negedge clk);
        addr_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic sel);
        if (i == 0) return {7'h3C | {6'd0, sel}, 1'b0};
        if (i == 1) return 8'h00;
        return EXP_CMDS[i-2];
    endfunction

    task automatic t_reset();
        chk(scl == 1'b1, "R1", "scl after reset", scl, 1);
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        chk({busy, done, err} == 3'b000, "R1", "busy/done/err after reset", {busy, done, err}, 0);
    endtask

    task automatic t_full(input logic sel);
        int mism = 0;
        clear_model(7'h3C | {6'd0, sel}, -1);
        pulse_start(sel);
        chk(busy && !done && !err, "R9", "flags right after start", {busy, done, err}, 3'b100);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(nbytes == 27, "R2", "byte count", nbytes, 27);
        for (int i = 0; i < 27; i++) if (log_b[i] !== exp_byte(i, sel)) mism++;
        chk(mism == 0, "R2", "bytes differing from command list", mism, 0);
        chk(log_b[0] == exp_byte(0, sel), "R3", "address byte", log_b[0], exp_byte(0, sel));
        chk(starts == 1 && stops == 1, "R5", "start/stop conditions", starts * 16 + stops, 8'h11);
        chk(ack_drive == 0, "R6", "ack clocks with sda_oe high", ack_drive, 0);
        chk(lo_min == LOW_C && lo_max == LOW_C, "R4", "scl low length min/max", lo_min * 256 + lo_max, LOW_C * 257);
        chk(hi_min == HIGH_C && hi_max == HIGH_C, "R4", "scl high length min/max", hi_min * 256 + hi_max, HIGH_C * 257);
        chk(done && !err, "R8", "done/err after success", {done, err}, 2'b10);
        chk(!busy && scl && !sda_oe, "R10", "bus idle after end", {busy, scl, sda_oe}, 3'b010);
        repeat (50) @(negedge clk);
        chk(done && !err, "R8", "done held", {done, err}, 2'b10);
    endtask

    task automatic t_nack(input logic sel, input logic [6:0] a, input int nk, input int exp_n);
        clear_model(a, nk);
        pulse_start(sel);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(nbytes == exp_n, "R7", "bytes before abort", nbytes, exp_n);
        chk(stops == 1, "R7", "stop after nack", stops, 1);
        chk(err && !done, "R7", "err/done after nack", {done, err}, 2'b01);
        chk(!busy && scl && !sda_oe, "R10", "bus idle after abort", {busy, scl, sda_oe}, 3'b010);
    endtask

    task automatic t_restart_busy_start();
        clear_model(7'h3D, -1);
        pulse_start(1'b1);
        chk(!err && !done && busy, "R9", "err cleared by new start", {busy, done, err}, 3'b100);
        repeat (300) @(negedge clk);
        pulse_start(1'b0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(starts == 1, "R9", "start conditions with start while busy", starts, 1);
        chk(nbytes == 27 && log_b[0] == 8'h7A, "R9", "run unchanged by start while busy", nbytes, 27);
        chk(done && !err, "R8", "done after restart", {done, err}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full(1'b0);
        t_full(1'b1);
        t_nack(1'b0, 7'h3D, -1, 1);
        t_nack(1'b1, 7'h3D, 5, 6);
        t_nack(1'b0, 7'h3C, 26, 27);
        t_restart_busy_start();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule